// File: doc/BRIEF.md
# Dual Stack Pointer Interrupt Interlock

This block keeps the two stack pointers of a small nibble-oriented CPU core. One pointer serves word-wide (16-bit) stack traffic and is 10 bits wide. The other serves nibble-wide stack traffic and is 8 bits wide. Software loads each pointer through its own write port. The core moves the pointers with push and pop strobes. A push moves the pointer down first and then writes at the new value. A pop reads at the current value and then moves the pointer up. Both pointers wrap modulo their width.

The block also drives an interrupt-permit signal. The core uses it to gate every interrupt source, the non-maskable one included. The permit is held low until software has loaded both pointers. Once both are loaded, loading either one again drops the permit, and it stays low until the other pointer is loaded as well. Software must therefore always load the two pointers as a pair.

Word-stack accesses are valid only inside a fixed window of addresses. The block flags any word-stack push or pop whose effective address falls outside that window. The flagged access still takes place.

Top module: `stack_ptr_interlock`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, both pointers read zero and `irq_permit` is low.
- R2: The word pointer is 10 bits wide and wraps. A push at 0x000 gives 0x3FF, and a pop at 0x3FF gives 0x000.
- R3: The nibble pointer is 8 bits wide and wraps. A push at 0x00 gives 0xFF, and a pop at 0xFF gives 0x00.
- R4: After reset, `irq_permit` goes high only once both pointers have been written. It rises in the cycle after the clock edge that completes the pair.
- R5: While `irq_permit` is high, a write to only one pointer drops it after that edge. It stays low, even through further writes to the same pointer, until the other pointer is written.
- R6: Writing both pointers in the same cycle completes a pair. This holds whether the permit was high or low before.
- R7: A push decrements its pointer and presents the decremented value as the access address in the strobe cycle. A pop presents the current value as the address and increments the pointer at the edge.
- R8: Push and pop strobes never change `irq_permit`.
- R9: When a software write and a push or pop strike the same pointer in the same cycle, the written value is loaded. The strobe is dropped and is not flagged.
- R10: `wsp_range_err` is high in a cycle exactly when a word push or pop is taking effect and its access address lies below 0x100 or above 0x1FF. The pointer still moves.
- R11: When push and pop are both asserted for the same pointer in one cycle, the push is performed and the pop is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wsp_wr | input | 1 | Software load of the word pointer |
| wsp_wdata | input | 10 | Value to load into the word pointer |
| nsp_wr | input | 1 | Software load of the nibble pointer |
| nsp_wdata | input | 8 | Value to load into the nibble pointer |
| wsp_push | input | 1 | Word push strobe |
| wsp_pop | input | 1 | Word pop strobe |
| nsp_push | input | 1 | Nibble push strobe |
| nsp_pop | input | 1 | Nibble pop strobe |
| wsp | output | 10 | Current word pointer |
| nsp | output | 8 | Current nibble pointer |
| wsp_addr | output | 10 | Word stack access address for this cycle |
| nsp_addr | output | 8 | Nibble stack access address for this cycle |
| wsp_range_err | output | 1 | Word access outside the 16-bit window |
| irq_permit | output | 1 | Interrupts (NMI included) may be taken |

## Verification
The bench targets the pairing rule at its edges. One case rewrites the same pointer twice in a row; a design that counted writes instead of tracking which pointer was written would wrongly reopen the permit. Another writes both pointers in one cycle; a design that cleared the flags after setting them would wrongly lock interrupts. The bench also checks wrap-around at both ends of each pointer, the window boundaries 0x0FF/0x100 and 0x1FF/0x200 for push and pop separately, and the priority of a write over a same-cycle strobe. An off-by-one in the push address or the window compare shows up as a wrong error flag. A wrong priority leaves the pointer at a strobed value instead of the written one.

// File: rtl/stack_ptr_interlock.sv
module stack_ptr_interlock #(
  parameter int WSP_W = 10,
  parameter int NSP_W = 8,
  parameter logic [WSP_W-1:0] WIN_LO = 'h100,
  parameter logic [WSP_W-1:0] WIN_HI = 'h1FF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wsp_wr,
  input  logic [WSP_W-1:0] wsp_wdata,
  input  logic             nsp_wr,
  input  logic [NSP_W-1:0] nsp_wdata,
  input  logic             wsp_push,
  input  logic             wsp_pop,
  input  logic             nsp_push,
  input  logic             nsp_pop,
  output logic [WSP_W-1:0] wsp,
  output logic [NSP_W-1:0] nsp,
  output logic [WSP_W-1:0] wsp_addr,
  output logic [NSP_W-1:0] nsp_addr,
  output logic             wsp_range_err,
  output logic             irq_permit
);

  localparam logic [WSP_W-1:0] W_ONE = 1;
  localparam logic [NSP_W-1:0] N_ONE = 1;

  logic w_seen, n_seen;
  logic paired;
  logic w_op;

  assign paired     = w_seen & n_seen;
  assign irq_permit = paired;

  assign wsp_addr = wsp_push ? wsp - W_ONE : wsp;
  assign nsp_addr = nsp_push ? nsp - N_ONE : nsp;

  assign w_op          = (wsp_push | wsp_pop) & ~wsp_wr;
  assign wsp_range_err = w_op & ((wsp_addr < WIN_LO) | (wsp_addr > WIN_HI));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wsp <= '0;
      nsp <= '0;
    end else begin
      if (wsp_wr)        wsp <= wsp_wdata;
      else if (wsp_push) wsp <= wsp - W_ONE;
      else if (wsp_pop)  wsp <= wsp + W_ONE;
      if (nsp_wr)        nsp <= nsp_wdata;
      else if (nsp_push) nsp <= nsp - N_ONE;
      else if (nsp_pop)  nsp <= nsp + N_ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      w_seen <= 1'b0;
      n_seen <= 1'b0;
    end else begin
      if (wsp_wr)                w_seen <= 1'b1;
      else if (nsp_wr && paired) w_seen <= 1'b0;
      if (nsp_wr)                n_seen <= 1'b1;
      else if (wsp_wr && paired) n_seen <= 1'b0;
    end
  end

  a_r1_reset_state: assert property (@(posedge clk)
    !rst_n |=> (wsp == '0 && nsp == '0 && !irq_permit));

  a_r2_wsp_push_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!wsp_wr && wsp_push) |=> wsp == $past(wsp) - W_ONE);

  a_r3_nsp_pop_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!nsp_wr && !nsp_push && nsp_pop) |=> nsp == $past(nsp) + N_ONE);

  a_r4_permit_rises_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_permit) |-> $past(wsp_wr || nsp_wr));

  a_r5_single_rewrite_masks: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_permit && (wsp_wr != nsp_wr)) |=> !irq_permit);

  a_r6_pair_write_permits: assert property (@(posedge clk) disable iff (!rst_n)
    (wsp_wr && nsp_wr) |=> irq_permit);

  a_r8_strobes_keep_permit: assert property (@(posedge clk) disable iff (!rst_n)
    (!wsp_wr && !nsp_wr) |=> $stable(irq_permit));

  a_r9_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wsp_wr |=> wsp == $past(wsp_wdata));

  a_r10_err_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    wsp_range_err |-> ((wsp_push || wsp_pop) && !wsp_wr));

endmodule

// File: tb/stack_ptr_interlock_tb.sv
`timescale 1ns/1ps
module stack_ptr_interlock_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wsp_wr = 0, nsp_wr = 0, wsp_push = 0, wsp_pop = 0, nsp_push = 0, nsp_pop = 0;
  logic [9:0] wsp_wdata = '0;
  logic [7:0] nsp_wdata = '0;
  logic [9:0] wsp, wsp_addr;
  logic [7:0] nsp, nsp_addr;
  logic wsp_range_err, irq_permit;

  int checks = 0, fails = 0;
  bit done = 0;
  int m_w = 0, m_n = 0, m_fw = 0, m_fn = 0;

  always #2 clk = ~clk;

  stack_ptr_interlock u_dut (
    .clk(clk), .rst_n(rst_n),
    .wsp_wr(wsp_wr), .wsp_wdata(wsp_wdata), .nsp_wr(nsp_wr), .nsp_wdata(nsp_wdata),
    .wsp_push(wsp_push), .wsp_pop(wsp_pop), .nsp_push(nsp_push), .nsp_pop(nsp_pop),
    .wsp(wsp), .nsp(nsp), .wsp_addr(wsp_addr), .nsp_addr(nsp_addr),
    .wsp_range_err(wsp_range_err), .irq_permit(irq_permit));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    int ea, ena, ee;
    ea  = wsp_push ? ((m_w + 1023) % 1024) : m_w;
    ena = nsp_push ? ((m_n + 255) % 256) : m_n;
    ee  = ((wsp_push || wsp_pop) && !wsp_wr && (ea < 256 || ea > 511)) ? 1 : 0;
    chk("R2 R7 R9 R11 wsp", int'(wsp), m_w);
    chk("R3 R7 R11 nsp", int'(nsp), m_n);
    chk("R4 R5 R6 R8 irq_permit", int'(irq_permit), m_fw & m_fn);
    chk("R7 wsp_addr", int'(wsp_addr), ea);
    chk("R7 R11 nsp_addr", int'(nsp_addr), ena);
    chk("R10 wsp_range_err", int'(wsp_range_err), ee);
  endtask

  task automatic step(bit ww, int wd, bit nw, int nd, bit wpu, bit wpo, bit npu, bit npo);
    int both;
    wsp_wr = ww; wsp_wdata = wd[9:0]; nsp_wr = nw; nsp_wdata = nd[7:0];
    wsp_push = wpu; wsp_pop = wpo; nsp_push = npu; nsp_pop = npo;
    #1 compare_all();
    @(posedge clk);
    both = m_fw & m_fn;
    if (ww) m_fw = 1; else if (nw && both) m_fw = 0;
    if (nw) m_fn = 1; else if (ww && both) m_fn = 0;
    if (ww) m_w = wd & 1023; else if (wpu) m_w = (m_w + 1023) % 1024; else if (wpo) m_w = (m_w + 1) % 1024;
    if (nw) m_n = nd & 255;  else if (npu) m_n = (m_n + 255) % 256;   else if (npo) m_n = (m_n + 1) % 256;
    @(negedge clk);
  endtask

  task automatic idle(); step(0,0,0,0,0,0,0,0); endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset wsp", int'(wsp), 0);
    chk("R1 reset nsp", int'(nsp), 0);
    chk("R1 reset permit", int'(irq_permit), 0);
    rst_n = 1'b1;
    idle();
    // R4: only one pointer written, permit stays low across stack traffic
    step(1,'h180,0,0,0,0,0,0);
    step(0,0,0,0,1,0,0,0);
    step(0,0,0,0,0,1,1,0);
    idle();
    step(0,0,1,'h40,0,0,0,0);
    idle();
    // R8: strobes with permit high
    step(0,0,0,0,1,0,1,0);
    step(0,0,0,0,0,1,0,1);
    // R5: rewrite one pointer twice, then the other
    step(1,'h1C0,0,0,0,0,0,0);
    step(0,0,0,0,0,0,1,0);
    step(1,'h1B0,0,0,0,0,0,0);
    idle();
    step(0,0,1,'h30,0,0,0,0);
    idle();
    step(0,0,1,'h20,0,0,0,0);
    step(0,0,1,'h21,0,0,0,0);
    step(1,'h150,0,0,0,0,0,0);
    // R6: both written in one cycle, from high and from low
    step(1,'h120,1,'h60,0,0,0,0);
    step(1,'h121,0,0,0,0,0,0);
    step(1,'h122,1,'h61,0,0,0,0);
    idle();
    // R2 R10: wrap of word pointer
    step(1,0,1,0,0,0,0,0);
    step(0,0,0,0,1,0,0,0);
    step(0,0,0,0,0,1,0,0);
    // R3: wrap of nibble pointer
    step(0,0,0,0,0,0,1,0);
    step(0,0,0,0,0,0,0,1);
    // R10: window boundaries
    step(1,'h101,0,0,0,0,0,0);
    step(0,0,0,0,1,0,0,0);
    step(0,0,0,0,1,0,0,0);
    step(1,'h1FF,0,0,0,0,0,0);
    step(0,0,0,0,0,1,0,0);
    step(0,0,0,0,0,1,0,0);
    // R9: write beats strobe on same pointer
    step(1,'h3FF,1,'h7,1,0,0,1);
    step(1,'h100,0,0,0,1,1,0);
    // R11: push and pop together
    step(0,0,0,0,1,1,1,1);
    step(0,0,0,0,1,1,1,1);
    // mixed traffic
    for (int i = 0; i < 400; i++)
      step($urandom_range(0,7)==0, $urandom_range(0,1023), $urandom_range(0,7)==0, $urandom_range(0,255),
           $urandom_range(0,1), $urandom_range(0,1), $urandom_range(0,1), $urandom_range(0,1));
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule